// File: doc/BRIEF.md
# Byte Permute and Align Unit

This unit rearranges the bytes of 128-bit vectors in one of two ways. In permute mode, each byte of a control vector picks one byte of a source vector, or forces that result byte to zero. In align mode, two vectors are joined into a 32-byte value and a 16-byte window is cut from it at a byte offset. The offset comes from an 8-bit unsigned count.

Operands arrive with an input strobe. The result is captured in a register and presented one clock later together with a valid flag. Between strobes the registered result stays where it is, so a consumer can sample it late. Byte 0 of every vector is bits 7:0, and byte k is bits 8k+7:8k.

Top module: `byte_perm_align`

## Requirements
- R1: When op_sel = 0 (permute), result byte i is byte (c & 4'hF) of vec_a, where c is byte i of vec_b and bit 7 of c is clear.
- R2: When op_sel = 0 and bit 7 of control byte i is set, result byte i is 8'h00.
- R3: In permute mode, bits 6:4 of a control byte have no effect on the result. For example, control 8'h18 selects source byte 8 and 8'h13 selects source byte 3.
- R4: When op_sel = 1 (align) and the count n is below 16, result byte i is byte n+i of the 32-byte value {vec_a, vec_b}, with vec_b in the low half. A count of 0 returns vec_b, and a count of 15 returns vec_b byte 15 followed by vec_a bytes 0 to 14.
- R5: In align mode a count of 16 returns vec_a unchanged.
- R6: In align mode, for 16 < n < 32, result byte i is vec_a byte n-16+i where that index is below 16, and 8'h00 otherwise.
- R7: In align mode any count from 32 to 255 gives an all-zero result.
- R8: out_valid is high exactly one cycle after a cycle with in_valid high. out_data in that cycle holds the result for the operands sampled with the strobe.
- R9: While rst_n is low, out_valid and out_data are zero.
- R10: A cycle with in_valid low brings out_valid low in the next cycle and leaves out_data unchanged, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid in this cycle |
| op_sel | input | 1 | 0 = byte permute, 1 = byte align |
| shift_amt | input | 8 | Align byte offset, unsigned |
| vec_a | input | 128 | Source vector; upper half of the align concatenation |
| vec_b | input | 128 | Permute control vector, or lower half of the align concatenation |
| out_valid | output | 1 | out_data carries a new result |
| out_data | output | 128 | Registered result |

## Verification
Every cycle, the assertions check the strobe-to-valid timing, that out_data holds during idle cycles, and that a permute byte whose control bit 7 is set gives zero. They also check the fixed align counts: 0 returns vec_b, 16 returns vec_a, and 32 or more gives zero. Other behaviour can only be shown by the bench's scenarios, which compare results against an independent model. This covers nibble selection with bits 6:4 ignored, windows that span both halves, zero fill above 16, and the counts 15, 17, 31 and 255.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
    typedef enum logic {
        OP_PERMUTE = 1'b0,
        OP_ALIGN   = 1'b1
    } bpa_op_e;
endpackage

// File: rtl/bpa_permute.sv
module bpa_permute #(
    parameter int BYTES = 16,
    parameter int BW    = 8
) (
    input  logic [BYTES*BW-1:0] src,
    input  logic [BYTES*BW-1:0] ctl,
    output logic [BYTES*BW-1:0] res
);
    localparam int IDXW = $clog2(BYTES);

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [BW-1:0]   ctl_byte;
        logic [IDXW-1:0] pick;
        assign ctl_byte = ctl[g*BW +: BW];
        assign pick     = ctl_byte[IDXW-1:0];
        always_comb begin
            if (ctl_byte[BW-1]) res[g*BW +: BW] = '0;
            else                res[g*BW +: BW] = src[pick*BW +: BW];
        end
    end
endmodule

// File: rtl/bpa_align.sv
module bpa_align #(
    parameter int BYTES = 16,
    parameter int BW    = 8,
    parameter int SHW   = 8
) (
    input  logic [BYTES*BW-1:0] hi,
    input  logic [BYTES*BW-1:0] lo,
    input  logic [SHW-1:0]      amt,
    output logic [BYTES*BW-1:0] res
);
    localparam int SPAN = 2 * BYTES;
    localparam int SELW = $clog2(SPAN);
    localparam int POSW = SHW + 1;

    logic [SPAN*BW-1:0] joined;
    assign joined = {hi, lo};

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [POSW-1:0] pos;
        logic [SELW-1:0] sel;
        assign pos = {1'b0, amt} + POSW'(g);
        assign sel = pos[SELW-1:0];
        always_comb begin
            if (pos < POSW'(SPAN)) res[g*BW +: BW] = joined[sel*BW +: BW];
            else                   res[g*BW +: BW] = '0;
        end
    end
endmodule

// File: rtl/byte_perm_align.sv
module byte_perm_align #(
    parameter int BYTES = 16,
    parameter int BW    = 8,
    parameter int SHW   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 op_sel,
    input  logic [SHW-1:0]       shift_amt,
    input  logic [BYTES*BW-1:0]  vec_a,
    input  logic [BYTES*BW-1:0]  vec_b,
    output logic                 out_valid,
    output logic [BYTES*BW-1:0]  out_data
);
    import bpa_pkg::*;

    localparam int VW = BYTES * BW;

    bpa_op_e     op;
    logic [VW-1:0] perm_res;
    logic [VW-1:0] align_res;
    logic [VW-1:0] next_res;

    assign op = bpa_op_e'(op_sel);

    bpa_permute #(.BYTES(BYTES), .BW(BW)) u_permute (
        .src (vec_a),
        .ctl (vec_b),
        .res (perm_res)
    );

    bpa_align #(.BYTES(BYTES), .BW(BW), .SHW(SHW)) u_align (
        .hi  (vec_a),
        .lo  (vec_b),
        .amt (shift_amt),
        .res (align_res)
    );

    always_comb begin
        unique case (op)
            OP_PERMUTE: next_res = perm_res;
            OP_ALIGN:   next_res = align_res;
            default:    next_res = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= next_res;
        end
    end
endmodule

// File: rtl/bpa_checker.sv
module bpa_checker #(
    parameter int BYTES = 16,
    parameter int BW    = 8,
    parameter int SHW   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                op_sel,
    input logic [SHW-1:0]      shift_amt,
    input logic [BYTES*BW-1:0] vec_a,
    input logic [BYTES*BW-1:0] vec_b,
    input logic                out_valid,
    input logic [BYTES*BW-1:0] out_data
);
    always_comb begin
        if (!rst_n) begin
            assert_reset_clear_R9: assert (out_valid == 1'b0 && out_data == '0);
        end
    end

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_drops_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_idle_holds_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    assert_align_zero_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel && shift_amt == '0) |=> out_data == $past(vec_b));

    assert_align_full_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel && shift_amt == SHW'(BYTES)) |=> out_data == $past(vec_a));

    assert_align_beyond_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel && shift_amt >= SHW'(2 * BYTES)) |=> out_data == '0);

    for (genvar g = 0; g < BYTES; g++) begin : g_zero
        assert_permute_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !op_sel && vec_b[g*BW + BW - 1]) |=> out_data[g*BW +: BW] == '0);
    end
endmodule

bind byte_perm_align bpa_checker #(.BYTES(BYTES), .BW(BW), .SHW(SHW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .shift_amt (shift_amt),
    .vec_a     (vec_a),
    .vec_b     (vec_b),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/byte_perm_align_tb.sv
module byte_perm_align_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         op_sel = 1'b0;
    logic [7:0]   shift_amt = '0;
    logic [127:0] vec_a = '0;
    logic [127:0] vec_b = '0;
    logic         out_valid;
    logic [127:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    byte_perm_align dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .shift_amt(shift_amt), .vec_a(vec_a), .vec_b(vec_b),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [127:0] model_permute(logic [127:0] a, logic [127:0] b);
        logic [127:0] r = '0;
        for (int i = 0; i < 16; i++) begin
            logic [7:0] c = b[i*8 +: 8];
            if (!c[7]) r[i*8 +: 8] = a[int'(c[3:0])*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [127:0] model_align(logic [127:0] a, logic [127:0] b, int n);
        logic [127:0] r = '0;
        for (int i = 0; i < 16; i++) begin
            int k = n + i;
            if (k < 16)      r[i*8 +: 8] = b[k*8 +: 8];
            else if (k < 32) r[i*8 +: 8] = a[(k-16)*8 +: 8];
        end
        return r;
    endfunction

    function automatic string tag_for(logic op, int n);
        if (!op)      return "R1/R2/R3";
        if (n < 16)   return "R4";
        if (n == 16)  return "R5";
        if (n < 32)   return "R6";
        return "R7";
    endfunction

    task automatic check_vec(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic run_op(logic op, int n, logic [127:0] a, logic [127:0] b,
                          bit idle_check, output logic [127:0] got);
        logic [127:0] exp;
        exp = op ? model_align(a, b, n) : model_permute(a, b);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; shift_amt = 8'(n); vec_a = a; vec_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit("R8 valid", out_valid, 1'b1);
        check_vec(tag_for(op, n), out_data, exp);
        got = out_data;
        if (idle_check) begin
            vec_a = ~a; vec_b = ~b; op_sel = ~op;
            @(negedge clk);
            check_bit("R10 valid", out_valid, 1'b0);
            check_vec("R10 hold", out_data, exp);
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        logic [127:0] seq_a, ctl, got;
        void'($urandom(32'd4021));
        for (int i = 0; i < 16; i++) seq_a[i*8 +: 8] = 8'(i + 1);

        repeat (3) @(negedge clk);
        check_bit("R9 valid", out_valid, 1'b0);
        check_vec("R9 data", out_data, '0);
        rst_n = 1'b1;

        // permute: zero, nibble pick, upper control bits ignored
        ctl = {8'h00, 8'h08, 8'h01, 8'h04, 8'h0A, 8'h05, 8'h05, 8'h0C,
               8'h13, 8'h06, 8'h0C, 8'h18, 8'h03, 8'h04, 8'h80, 8'h04};
        run_op(1'b0, 0, seq_a, ctl, 1'b1, got);
        check_vec("R3 ctl 8'h18", {120'h0, got[39:32]}, 128'd9);
        check_vec("R3 ctl 8'h13", {120'h0, got[63:56]}, 128'd4);
        check_vec("R2 ctl 8'h80", {120'h0, got[15:8]}, 128'd0);
        run_op(1'b0, 0, rnd128(), {16{8'hFF}}, 1'b0, got);
        check_vec("R2 all zero", got, '0);
        run_op(1'b0, 0, seq_a, {16{8'h7F}}, 1'b0, got);
        check_vec("R3 ctl 8'h7F", got, {16{8'h10}});

        // align corner counts
        run_op(1'b1, 0,   seq_a, ctl, 1'b1, got);
        run_op(1'b1, 15,  seq_a, ctl, 1'b0, got);
        run_op(1'b1, 16,  seq_a, ctl, 1'b0, got);
        run_op(1'b1, 17,  seq_a, ctl, 1'b1, got);
        run_op(1'b1, 31,  seq_a, ctl, 1'b0, got);
        run_op(1'b1, 32,  seq_a, ctl, 1'b0, got);
        run_op(1'b1, 255, seq_a, ctl, 1'b1, got);

        for (int t = 0; t < 300; t++) begin
            logic op = 1'($urandom);
            int n = ($urandom % 4 == 0) ? int'($urandom % 256) : int'($urandom % 34);
            run_op(op, n, rnd128(), rnd128(), (t % 7 == 0), got);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule